// File: doc/BRIEF.md
# Three-Channel Event Timer with Fixed Legacy Routing

This block keeps a 64-bit main count that advances by one on each cycle where the tick-enable input is high. Three timers compare their own 64-bit match values against that count. When a timer matches, it signals an interrupt either as a single-cycle pulse or as a held level. A held level stays asserted until software writes one to the timer's status bit. The timers are set up and observed over a simple register port with single-cycle writes and combinational reads.

Two arrays of interrupt lines leave the block: 16 lines towards a legacy interrupt controller and 24 lines towards an advanced interrupt controller. In normal operation each timer drives the advanced-controller line chosen by its route field. A legacy-routing switch overrides this. With the switch set, timers 0 and 1 go to fixed lines on both controllers, and timer 2 also drives a fixed legacy line. A master enable gates the counter and every interrupt output, but it does not discard pending level status.

Top module: `evt_timer`

## Requirements
- R1: Offset 0x000 reads 0x00000001 (revision in bits 7:0) and offset 0x004 reads 0x0429B17F (tick period). Writes to either offset leave the value read unchanged.
- R2: The global control word at 0x010 resets to zero. Bit 0 is the master enable and bit 1 is the legacy-routing switch. Bits 31:2 always read zero.
- R3: The main count (low word at 0x0F0, high word at 0x0F4) rises by exactly one on each clock where tick_i is high and the master enable is set, carrying from the low word into the high word. While the enable is clear it holds its value.
- R4: Writes to the count words take effect only while the master enable is clear. They are ignored while it is set.
- R5: While the master enable is clear, every bit of pic_irq_o and apic_irq_o is low.
- R6: Timer n has a control word at 0x100+0x20*n (bit 0 level=1/pulse=0, bit 1 interrupt enable, bits 8:4 route) and a match value at +0x08 (low) and +0x0C (high). It fires on a ticking, enabled cycle where the count equals its match value. In level mode this sets bit n of the status word at 0x020, and the output is high from the next cycle.
- R7: A pulse-mode timer with interrupt enable set drives its output high for exactly the one cycle after the match and does not set its status bit.
- R8: Writing 1 to bit n of 0x020 clears status bit n, and writing 0 leaves it unchanged. If a match sets the bit in the same cycle as a clear, the bit stays set.
- R9: Clearing the master enable leaves set status bits set. Outputs return once the enable is set again.
- R10: With legacy routing off, timer n drives apic_irq_o[route] when route < 24, drives nothing when route ≥ 24, and never drives pic_irq_o.
- R11: With legacy routing on, timer 0 drives pic_irq_o[0] and apic_irq_o[2], and timer 1 drives pic_irq_o[8] and apic_irq_o[8]. The route fields of timers 0 and 1 are ignored.
- R12: With legacy routing on, timer 2 drives pic_irq_o[11] and also apic_irq_o[route] from its own route field.
- R13: A timer whose interrupt enable is clear neither sets status nor drives any output on a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-advance qualifier |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high with req_i |
| addr_i | input | 12 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pic_irq_o | output | 16 | Lines to the legacy interrupt controller |
| apic_irq_o | output | 24 | Lines to the advanced interrupt controller |

## Verification
A software clear of a timer's status bit can land in the same clock as a fresh match of that timer. The bench arranges this by parking the count on the match value while the block is disabled and then enabling it. It then issues the write-one-to-clear with tick_i raised in that same cycle. The outcome is judged by reading the status word on the next cycle and by the level on the routed line: both must show the bit still set. A separate plain clear must then drop both.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int ADDR_W  = 12;
  localparam int ROUTE_W = 5;

  localparam logic [31:0] REV_WORD    = 32'h0000_0001;
  localparam logic [31:0] PERIOD_WORD = 32'h0429_B17F;

  localparam logic [ADDR_W-1:0] OFF_CAP_LO  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_CAP_HI  = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_GCTL    = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_GSTS    = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO  = 12'h0F0;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI  = 12'h0F4;
  localparam int                TMR_BASE    = 'h100;
  localparam int                TMR_STRIDE  = 'h20;
  localparam int                TMR_CMP_LO  = 'h08;
  localparam int                TMR_CMP_HI  = 'h0C;

  // fixed legacy line numbers
  localparam int LEG_T0_PIC  = 0;
  localparam int LEG_T0_APIC = 2;
  localparam int LEG_T1_LINE = 8;
  localparam int LEG_T2_PIC  = 11;

  typedef struct packed {
    logic [ROUTE_W-1:0] route;
    logic               int_en;
    logic               level;
  } tcfg_t;

  function automatic logic [ADDR_W-1:0] tmr_addr(int idx, int off);
    return ADDR_W'(TMR_BASE + idx * TMR_STRIDE + off);
  endfunction
endpackage

// File: rtl/evt_timer_unit.sv
module evt_timer_unit
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cmp_lo_we_i,
  input  logic             cmp_hi_we_i,
  input  logic [31:0]      wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             sts_clr_i,
  output tcfg_t            cfg_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             sts_o,
  output logic             irq_o
);
  tcfg_t            cfg_q;
  logic [CNT_W-1:0] cmp_q;
  logic             sts_q, pulse_q, hit;

  assign hit = en_i & tick_i & cfg_q.int_en & (cnt_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      cmp_q   <= '1;
      sts_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        cfg_q.level  <= wdata_i[0];
        cfg_q.int_en <= wdata_i[1];
        cfg_q.route  <= wdata_i[4 +: ROUTE_W];
      end
      if (cmp_lo_we_i) cmp_q[31:0]       <= wdata_i;
      if (cmp_hi_we_i) cmp_q[CNT_W-1:32] <= wdata_i[CNT_W-33:0];
      // set beats clear
      if (hit && cfg_q.level)  sts_q <= 1'b1;
      else if (sts_clr_i)      sts_q <= 1'b0;
      pulse_q <= hit & ~cfg_q.level;
    end
  end

  assign irq_o = en_i & (cfg_q.level ? sts_q : pulse_q);
  assign cfg_o = cfg_q;
  assign cmp_o = cmp_q;
  assign sts_o = sts_q;

  a_r6_level_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && cfg_q.level) |=> sts_q);
  a_r7_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
  a_r8_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_clr_i && !hit) |=> !sts_q);
  a_r9_status_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q && !sts_clr_i) |=> sts_q);
endmodule

// File: rtl/evt_timer_route.sv
module evt_timer_route
  import evt_timer_pkg::*;
#(
  parameter int NUM_T  = 3,
  parameter int PIC_N  = 16,
  parameter int APIC_N = 24
) (
  input  logic                            legacy_i,
  input  logic [NUM_T-1:0]                irq_i,
  input  logic [NUM_T-1:0][ROUTE_W-1:0]   route_i,
  output logic [PIC_N-1:0]                pic_o,
  output logic [APIC_N-1:0]               apic_o
);
  always_comb begin
    pic_o  = '0;
    apic_o = '0;
    for (int t = 0; t < NUM_T; t++) begin
      if (!(legacy_i && t < 2) && int'(route_i[t]) < APIC_N)
        apic_o[int'(route_i[t])] = apic_o[int'(route_i[t])] | irq_i[t];
    end
    if (legacy_i) begin
      pic_o[LEG_T0_PIC]   = pic_o[LEG_T0_PIC]   | irq_i[0];
      apic_o[LEG_T0_APIC] = apic_o[LEG_T0_APIC] | irq_i[0];
      pic_o[LEG_T1_LINE]  = pic_o[LEG_T1_LINE]  | irq_i[1];
      apic_o[LEG_T1_LINE] = apic_o[LEG_T1_LINE] | irq_i[1];
      pic_o[LEG_T2_PIC]   = pic_o[LEG_T2_PIC]   | irq_i[2];
    end
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int NUM_T  = 3,
  parameter int CNT_W  = 64,
  parameter int PIC_N  = 16,
  parameter int APIC_N = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [PIC_N-1:0]  pic_irq_o,
  output logic [APIC_N-1:0] apic_irq_o
);
  logic                          wr, en_q, leg_q;
  logic [CNT_W-1:0]              cnt_q;
  logic [NUM_T-1:0]              sts, irq_t;
  logic [NUM_T-1:0][ROUTE_W-1:0] route;
  tcfg_t                         tcfg     [NUM_T];
  logic [CNT_W-1:0]              tcmp     [NUM_T];

  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      leg_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (wr && addr_i == OFF_GCTL) begin
        en_q  <= wdata_i[0];
        leg_q <= wdata_i[1];
      end
      if (!en_q && wr && addr_i == OFF_CNT_LO)      cnt_q[31:0]       <= wdata_i;
      else if (!en_q && wr && addr_i == OFF_CNT_HI) cnt_q[CNT_W-1:32] <= wdata_i[CNT_W-33:0];
      else if (en_q && tick_i)                      cnt_q             <= cnt_q + 1'b1;
    end
  end

  for (genvar t = 0; t < NUM_T; t++) begin : g_tmr
    evt_timer_unit #(.CNT_W(CNT_W)) u_unit (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_we_i    (wr && addr_i == tmr_addr(t, 0)),
      .cmp_lo_we_i (wr && addr_i == tmr_addr(t, TMR_CMP_LO)),
      .cmp_hi_we_i (wr && addr_i == tmr_addr(t, TMR_CMP_HI)),
      .wdata_i     (wdata_i),
      .cnt_i       (cnt_q),
      .en_i        (en_q),
      .tick_i      (tick_i),
      .sts_clr_i   (wr && addr_i == OFF_GSTS && wdata_i[t]),
      .cfg_o       (tcfg[t]),
      .cmp_o       (tcmp[t]),
      .sts_o       (sts[t]),
      .irq_o       (irq_t[t])
    );
    assign route[t] = tcfg[t].route;
  end

  evt_timer_route #(.NUM_T(NUM_T), .PIC_N(PIC_N), .APIC_N(APIC_N)) u_route (
    .legacy_i (leg_q),
    .irq_i    (irq_t),
    .route_i  (route),
    .pic_o    (pic_irq_o),
    .apic_o   (apic_irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_CAP_LO: rdata_o = REV_WORD;
      OFF_CAP_HI: rdata_o = PERIOD_WORD;
      OFF_GCTL:   rdata_o = {30'b0, leg_q, en_q};
      OFF_GSTS:   rdata_o[NUM_T-1:0] = sts;
      OFF_CNT_LO: rdata_o = cnt_q[31:0];
      OFF_CNT_HI: rdata_o[CNT_W-33:0] = cnt_q[CNT_W-1:32];
      default: ;
    endcase
    for (int t = 0; t < NUM_T; t++) begin
      if (addr_i == tmr_addr(t, 0))
        rdata_o = {23'b0, tcfg[t].route, 2'b0, tcfg[t].int_en, tcfg[t].level};
      if (addr_i == tmr_addr(t, TMR_CMP_LO)) rdata_o = tcmp[t][31:0];
      if (addr_i == tmr_addr(t, TMR_CMP_HI)) rdata_o = {{(64-CNT_W){1'b0}}, tcmp[t][CNT_W-1:32]};
    end
  end

  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && tick_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r3_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !wr) |=> $stable(cnt_q));
  a_r4_write_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !tick_i && wr && (addr_i == OFF_CNT_LO || addr_i == OFF_CNT_HI)) |=> $stable(cnt_q));
  a_r5_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (pic_irq_o == '0 && apic_irq_o == '0));
  a_r11_leg_t0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (leg_q && irq_t[0]) |-> (pic_irq_o[LEG_T0_PIC] && apic_irq_o[LEG_T0_APIC]));
  a_r12_leg_t2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (leg_q && irq_t[2]) |-> pic_irq_o[LEG_T2_PIC]);
endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
  logic        clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [15:0] pic_irq_o;
  logic [23:0] apic_irq_o;
  int          errors = 0, checks = 0;
  logic        leg = 1'b0;

  always #10 clk_i = ~clk_i;

  evt_timer u_dut (.*);

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d, logic tk = 1'b0);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d; tick_i = tk;
    @(negedge clk_i);
    req_i = 0; we_i = 0; tick_i = 0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1;
      @(negedge clk_i); tick_i = 0;
    end
  endtask

  task automatic gctl(logic en);
    bus_wr(12'h010, {30'b0, leg, en});
  endtask

  task automatic arm(logic [63:0] v);
    gctl(0);
    bus_wr(12'h0F0, v[31:0]);
    bus_wr(12'h0F4, v[63:32]);
    gctl(1);
  endtask

  task automatic tcfg(int t, logic lvl, logic ie, logic [4:0] rt);
    bus_wr(12'(12'h100 + t * 32), {23'b0, rt, 2'b0, ie, lvl});
  endtask

  task automatic tcmp(int t, logic [63:0] v);
    bus_wr(12'(12'h108 + t * 32), v[31:0]);
    bus_wr(12'(12'h10C + t * 32), v[63:32]);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_rd(12'h010, d); chk("R2 reset gctl", d, 0);
    bus_rd(12'h020, d); chk("R2 reset status", d, 0);
    bus_rd(12'h0F0, d); chk("R3 reset count", d, 0);
    chk("R5 reset lines", {pic_irq_o, apic_irq_o}, 0);
  endtask

  task automatic t_caps;
    logic [31:0] d;
    bus_rd(12'h000, d); chk("R1 revision", d, 32'h1);
    bus_rd(12'h004, d); chk("R1 period", d, 32'h0429B17F);
    bus_wr(12'h000, '1); bus_wr(12'h004, 0);
    bus_rd(12'h000, d); chk("R1 revision after write", d, 32'h1);
    bus_rd(12'h004, d); chk("R1 period after write", d, 32'h0429B17F);
  endtask

  task automatic t_gctl;
    logic [31:0] d;
    bus_wr(12'h010, 32'hFFFF_FFFC);
    bus_rd(12'h010, d); chk("R2 reserved zero", d, 0);
    bus_wr(12'h010, 32'h3);
    bus_rd(12'h010, d); chk("R2 both bits", d, 3);
    bus_wr(12'h010, 0);
    bus_rd(12'h010, d); chk("R2 cleared", d, 0);
  endtask

  task automatic t_count;
    logic [31:0] d;
    bus_wr(12'h0F0, 32'h1234_5678); bus_wr(12'h0F4, 32'h9);
    bus_rd(12'h0F0, d); chk("R4 write lo while off", d, 32'h1234_5678);
    bus_rd(12'h0F4, d); chk("R4 write hi while off", d, 32'h9);
    gctl(1);
    step(3);
    bus_rd(12'h0F0, d); chk("R3 three ticks", d, 32'h1234_567B);
    bus_wr(12'h0F0, 0);
    bus_rd(12'h0F0, d); chk("R4 write ignored while on", d, 32'h1234_567B);
    gctl(0);
    step(2);
    bus_rd(12'h0F0, d); chk("R3 hold while off", d, 32'h1234_567B);
    arm(64'h0000_0000_FFFF_FFFF);
    step(1);
    bus_rd(12'h0F0, d); chk("R3 carry lo", d, 0);
    bus_rd(12'h0F4, d); chk("R3 carry hi", d, 1);
    gctl(0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    tcfg(0, 1, 1, 5); tcmp(0, 100);
    arm(100);
    bus_rd(12'h020, d); chk("R6 not yet", d, 0);
    step(1);
    bus_rd(12'h020, d); chk("R6 status set", d, 1);
    chk("R10 route 5", apic_irq_o, 24'h20);
    chk("R10 no pic", pic_irq_o, 0);
    step(1);
    bus_rd(12'h020, d); chk("R6 sticky", d, 1);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    gctl(0);
    bus_rd(12'h020, d); chk("R9 kept on disable", d, 1);
    chk("R5 lines low", {pic_irq_o, apic_irq_o}, 0);
    gctl(1);
    chk("R9 line back", apic_irq_o, 24'h20);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    bus_wr(12'h020, 32'h6);
    bus_rd(12'h020, d); chk("R8 zero no effect", d, 1);
    bus_wr(12'h020, 32'h1);
    bus_rd(12'h020, d); chk("R8 cleared", d, 0);
    chk("R8 line dropped", apic_irq_o, 0);
  endtask

  task automatic t_race;
    logic [31:0] d;
    arm(100); step(1);
    arm(100);
    bus_wr(12'h020, 32'h1, 1'b1);
    bus_rd(12'h020, d); chk("R8 set wins race", d, 1);
    chk("R8 line after race", apic_irq_o, 24'h20);
    bus_wr(12'h020, 32'h1);
    bus_rd(12'h020, d); chk("R8 later clear", d, 0);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    tcfg(1, 0, 1, 7); tcmp(1, 200);
    arm(200);
    @(negedge clk_i); tick_i = 1;
    @(negedge clk_i); tick_i = 0;
    chk("R7 pulse high", apic_irq_o, 24'h80);
    @(negedge clk_i);
    chk("R7 pulse gone", apic_irq_o, 0);
    bus_rd(12'h020, d); chk("R7 no status", d, 0);
  endtask

  task automatic t_noint;
    logic [31:0] d;
    tcfg(2, 1, 0, 9); tcmp(2, 300);
    arm(300); step(1);
    bus_rd(12'h020, d); chk("R13 no status", d, 0);
    chk("R13 no line", apic_irq_o, 0);
  endtask

  task automatic t_badroute;
    logic [31:0] d;
    tcfg(2, 1, 1, 30);
    arm(300); step(1);
    bus_rd(12'h020, d); chk("R10 status with bad route", d, 4);
    chk("R10 bad route silent", {pic_irq_o, apic_irq_o}, 0);
    bus_wr(12'h020, 32'h4);
  endtask

  task automatic t_legacy;
    logic [31:0] d;
    leg = 1'b1;
    tcfg(0, 1, 1, 5);  tcmp(0, 400);
    tcfg(1, 1, 1, 7);  tcmp(1, 400);
    tcfg(2, 1, 1, 9);  tcmp(2, 400);
    arm(400); step(1);
    bus_rd(12'h020, d); chk("R11 all status", d, 7);
    chk("R11 R12 pic lines", pic_irq_o, 16'h0901);
    chk("R11 R12 apic lines", apic_irq_o, 24'h000304);
    bus_wr(12'h020, 32'h3);
    chk("R12 t2 alone pic", pic_irq_o, 16'h0800);
    chk("R12 t2 alone apic", apic_irq_o, 24'h000200);
    bus_wr(12'h020, 32'h4);
    chk("R11 all clear", {pic_irq_o, apic_irq_o}, 0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_caps;
    t_gctl;
    t_count;
    t_level;
    t_disable;
    t_clear;
    t_race;
    t_edge;
    t_noint;
    t_badroute;
    t_legacy;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule